// File: doc/BRIEF.md
# Two-Window Peripheral Bus Requester

This block turns single read and write commands from a local requester into transfers on an APB-style peripheral bus. Each command passes through a one-cycle setup phase, where a slave select is raised with enable low, and then an access phase, where enable is raised. The access phase lasts until the addressed slave signals ready. When that happens the block returns one response pulse that carries the read data and an error flag.

Two slaves sit behind the block, and each one owns a 16-byte address window. Every slave drives its own read data, ready and error lines. The block routes back only the lines of the slave it has selected. An address outside both windows never reaches the bus and is answered with an error. While a transfer completes, the next command can be accepted, so back-to-back traffic moves from access straight into the next setup with no idle cycle in between.

Top module: `apbm_master`

## Requirements
- R1: While `rst_n` is low, every output is 0, including `cmd_ready`. After release and two clock edges, the block is idle with `cmd_ready` high and no select raised.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when idle, in the completing access cycle, or in the single error-answer cycle. It is low during setup and during access cycles where the selected slave is not ready.
- R3: Setup lasts exactly one cycle. In it exactly one bit of `bus_sel` is high and `bus_enable` is low. Access always follows it.
- R4: During access `bus_enable` is high, and `bus_addr`, `bus_write`, `bus_wdata` and `bus_sel` do not change while the selected slave holds ready low.
- R5: `bus_write` is 1 for a write command and 0 for a read command. `bus_addr` and `bus_wdata` carry the accepted command's address and data.
- R6: `bus_sel` bit 0 selects slave 0 for byte addresses 0x1000 to 0x100F. Bit 1 selects slave 1 for addresses 0x1010 to 0x101F. Slave i's lines are `slv_rdata[32*i +: 32]`, `slv_ready[i]` and `slv_err[i]`.
- R7: Ready, read data and error are taken only from the selected slave. The lines of a slave that is not selected have no effect.
- R8: On the edge where access meets a high selected ready, the block captures the read data (0 for writes) and the selected error (1 means error). It shows them on `rsp_rdata` and `rsp_err` with `rsp_valid` high for the following cycle.
- R9: An address outside both windows raises no select. The response comes one cycle after acceptance with `rsp_err` 1 and `rsp_rdata` 0.
- R10: If a command is waiting when access completes, it is accepted on that edge and the next cycle is a setup cycle for it.
- R11: For a mapped command, `rsp_valid` is high in the third cycle after the accepting edge, plus one cycle for every wait cycle the slave inserts. For an unmapped command it is high in the second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW (32) | Byte address |
| cmd_wdata | input | DW (32) | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW (32) | Captured read data |
| rsp_err | output | 1 | 1 = transfer failed |
| bus_addr | output | AW (32) | Bus address |
| bus_write | output | 1 | Bus direction |
| bus_wdata | output | DW (32) | Bus write data |
| bus_sel | output | NSLV (2) | One select per slave |
| bus_enable | output | 1 | Access phase marker |
| slv_rdata | input | NSLV*DW (64) | Read data, one lane per slave |
| slv_ready | input | NSLV (2) | Ready, one per slave |
| slv_err | input | NSLV (2) | Error, one per slave |

## Verification
On every cycle, the assertions check the shape of the phases. Setup lasts one cycle and leads into access. Selects are one-hot and fall inside their windows. Bus fields stay frozen during wait cycles. Every completing access yields a response, and a waiting command chains straight into setup. Only the bench scenarios can show the values that move through the block. These are read data taken from the correct lane while the other slave drives junk, errors from the selected slave only, writes that actually land, response latency under different wait counts, and the exact cycle trace of back-to-back transfers.

// File: rtl/apbm_pkg.sv
package apbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_FAULT  = 2'd3
  } phase_e;
endpackage

// File: rtl/apbm_decode.sv
module apbm_decode #(
  parameter int AW        = 32,
  parameter int NSLV      = 2,
  parameter logic [AW-1:0] BASE = 32'h0000_1000,
  parameter int WIN_BYTES = 16
) (
  input  logic [AW-1:0]   addr,
  output logic [NSLV-1:0] hit_oh,
  output logic            hit_any
);
  localparam int SHIFT = $clog2(WIN_BYTES);

  for (genvar i = 0; i < NSLV; i++) begin : g_win
    localparam logic [AW-1:0] WBASE = BASE + AW'(i * WIN_BYTES);
    assign hit_oh[i] = ((addr >> SHIFT) == (WBASE >> SHIFT));
  end

  assign hit_any = |hit_oh;
endmodule

// File: rtl/apbm_retmux.sv
module apbm_retmux #(
  parameter int DW   = 32,
  parameter int NSLV = 2
) (
  input  logic [NSLV-1:0]    sel_oh,
  input  logic [NSLV*DW-1:0] rdata_bus,
  input  logic [NSLV-1:0]    ready_bus,
  input  logic [NSLV-1:0]    err_bus,
  output logic [DW-1:0]      rdata,
  output logic               ready,
  output logic               err
);
  always_comb begin
    rdata = '0;
    ready = 1'b0;
    err   = 1'b0;
    for (int i = 0; i < NSLV; i++) begin
      if (sel_oh[i]) begin
        rdata = rdata | rdata_bus[i*DW +: DW];
        ready = ready | ready_bus[i];
        err   = err   | err_bus[i];
      end
    end
  end
endmodule

// File: rtl/apbm_master.sv
module apbm_master
  import apbm_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NSLV      = 2,
  parameter logic [AW-1:0] BASE = 32'h0000_1000,
  parameter int WIN_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [AW-1:0]       cmd_addr,
  input  logic [DW-1:0]       cmd_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_err,
  output logic [AW-1:0]       bus_addr,
  output logic                bus_write,
  output logic [DW-1:0]       bus_wdata,
  output logic [NSLV-1:0]     bus_sel,
  output logic                bus_enable,
  input  logic [NSLV*DW-1:0]  slv_rdata,
  input  logic [NSLV-1:0]     slv_ready,
  input  logic [NSLV-1:0]     slv_err
);
  // reset: asserted at once, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  phase_e          state_q, state_d;
  logic [AW-1:0]   addr_q;
  logic            write_q;
  logic [DW-1:0]   wdata_q;
  logic [NSLV-1:0] sel_q;
  logic            rsp_valid_q, rsp_err_q;
  logic [DW-1:0]   rsp_rdata_q;

  logic [NSLV-1:0] cmd_hit_oh;
  logic            cmd_hit_any;
  logic [DW-1:0]   m_rdata;
  logic            m_ready, m_err;
  logic            on_bus, done, accept, cmd_load, rsp_load;
  logic [DW-1:0]   rsp_rdata_d;
  logic            rsp_err_d;

  apbm_decode #(.AW(AW), .NSLV(NSLV), .BASE(BASE), .WIN_BYTES(WIN_BYTES)) u_dec (
    .addr    (cmd_addr),
    .hit_oh  (cmd_hit_oh),
    .hit_any (cmd_hit_any)
  );

  apbm_retmux #(.DW(DW), .NSLV(NSLV)) u_mux (
    .sel_oh    (bus_sel),
    .rdata_bus (slv_rdata),
    .ready_bus (slv_ready),
    .err_bus   (slv_err),
    .rdata     (m_rdata),
    .ready     (m_ready),
    .err       (m_err)
  );

  assign on_bus    = (state_q == PH_SETUP) || (state_q == PH_ACCESS);
  assign done      = ((state_q == PH_ACCESS) && m_ready) || (state_q == PH_FAULT);
  assign cmd_ready = rst_ok && ((state_q == PH_IDLE) || done);
  assign accept    = cmd_valid && cmd_ready;
  assign cmd_load  = accept;
  assign rsp_load  = done;

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:   if (accept) state_d = cmd_hit_any ? PH_SETUP : PH_FAULT;
      PH_SETUP:  state_d = PH_ACCESS;
      PH_ACCESS,
      PH_FAULT: begin
        if (accept)    state_d = cmd_hit_any ? PH_SETUP : PH_FAULT;
        else if (done) state_d = PH_IDLE;
      end
      default:   state_d = PH_IDLE;
    endcase
  end

  always_comb begin
    rsp_rdata_d = ((state_q == PH_ACCESS) && !write_q) ? m_rdata : '0;
    rsp_err_d   = (state_q == PH_FAULT) ? 1'b1 : m_err;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) state_q <= PH_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      sel_q   <= '0;
    end else if (cmd_load) begin
      addr_q  <= cmd_addr;
      write_q <= cmd_write;
      wdata_q <= cmd_wdata;
      sel_q   <= cmd_hit_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= done;
      if (rsp_load) begin
        rsp_rdata_q <= rsp_rdata_d;
        rsp_err_q   <= rsp_err_d;
      end
    end
  end

  assign bus_sel    = on_bus ? sel_q : '0;
  assign bus_enable = (state_q == PH_ACCESS);
  assign bus_addr   = addr_q;
  assign bus_write  = write_q;
  assign bus_wdata  = wdata_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign rsp_err    = rsp_err_q;
endmodule

// File: rtl/apbm_master_chk.sv
module apbm_master_chk #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NSLV      = 2,
  parameter logic [AW-1:0] BASE = 32'h0000_1000,
  parameter int WIN_BYTES = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            rsp_valid,
  input logic [DW-1:0]   rsp_rdata,
  input logic            rsp_err,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_write,
  input logic [DW-1:0]   bus_wdata,
  input logic [NSLV-1:0] bus_sel,
  input logic            bus_enable,
  input logic [NSLV-1:0] slv_ready
);
  localparam int SHIFT = $clog2(WIN_BYTES);
  logic sel_rdy;
  logic in_setup;
  assign sel_rdy  = |(bus_sel & slv_ready);
  assign in_setup = (|bus_sel) && !bus_enable;

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!cmd_ready && !rsp_valid && rsp_rdata == '0 && !rsp_err &&
                               bus_addr == '0 && !bus_write && bus_wdata == '0 &&
                               bus_sel == '0 && !bus_enable);
    end
  end

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(bus_sel));
  // R3
  setup_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |=> (bus_enable && $stable(bus_sel)));
  // R4
  enable_has_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_enable |-> (|bus_sel));
  // R4
  access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_enable && !sel_rdy) |=> (bus_enable && $stable(bus_addr) && $stable(bus_write) &&
                                  $stable(bus_wdata) && $stable(bus_sel)));
  // R2
  setup_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |-> !cmd_ready);
  // R2
  wait_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_enable && !sel_rdy) |-> !cmd_ready);
  // R8
  complete_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_enable && sel_rdy) |=> rsp_valid);
  // R10
  chain_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_enable && sel_rdy && cmd_valid) |=> (!bus_enable || rsp_valid));

  // R6
  for (genvar i = 0; i < NSLV; i++) begin : g_win
    localparam logic [AW-1:0] WBASE = BASE + AW'(i * WIN_BYTES);
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel[i] |-> ((bus_addr >> SHIFT) == (WBASE >> SHIFT)));
  end
endmodule

bind apbm_master apbm_master_chk #(
  .AW(AW), .DW(DW), .NSLV(NSLV), .BASE(BASE), .WIN_BYTES(WIN_BYTES)
) u_chk (.*);

// File: tb/sim_apbm_master.sv
module sim_apbm_master;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NV = 15;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [1:0]  wt;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h1000, 32'h1111_1111, 32'h0,          1'b0, 2'd0},
    '{1'b1, 32'h1004, 32'h2222_2222, 32'h0,          1'b0, 2'd1},
    '{1'b1, 32'h1014, 32'h3333_3333, 32'h0,          1'b0, 2'd2},
    '{1'b0, 32'h1000, 32'h0,         32'h1111_1111,  1'b0, 2'd0},
    '{1'b0, 32'h1014, 32'h0,         32'h3333_3333,  1'b0, 2'd3},
    '{1'b0, 32'h1004, 32'h0,         32'h2222_2222,  1'b0, 2'd1},
    '{1'b1, 32'h101C, 32'h4444_4444, 32'h0,          1'b1, 2'd0},
    '{1'b0, 32'h101C, 32'h0,         32'h0,          1'b1, 2'd2},
    '{1'b0, 32'h1020, 32'h0,         32'h0,          1'b1, 2'd0},
    '{1'b1, 32'h0FFC, 32'h6666_6666, 32'h0,          1'b1, 2'd0},
    '{1'b0, 32'h100C, 32'h0,         32'h0,          1'b0, 2'd0},
    '{1'b1, 32'h1010, 32'h5555_5555, 32'h0,          1'b0, 2'd1},
    '{1'b0, 32'h1010, 32'h0,         32'h5555_5555,  1'b0, 2'd0},
    '{1'b1, 32'h1008, 32'h7777_7777, 32'h0,          1'b0, 2'd2},
    '{1'b0, 32'h100B, 32'h0,         32'h7777_7777,  1'b0, 2'd0}
  };

  logic          clk, rst_n;
  logic          cmd_valid, cmd_ready, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_write, bus_enable;
  logic [DW-1:0] bus_wdata;
  logic [1:0]    bus_sel;
  logic [2*DW-1:0] slv_rdata;
  logic [1:0]    slv_ready, slv_err;

  int checks = 0;
  int failures = 0;
  int wait_cfg = 0;
  bit done_flag = 0;

  apbm_master u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // slave models: unselected slaves drive junk, ready and error high
  int          wcnt [2];
  logic [31:0] mem [2][4];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      if (bus_sel[i]) begin
        slv_rdata[i*DW +: DW] = mem[i][bus_addr[3:2]];
        slv_ready[i] = bus_enable ? (wcnt[i] >= wait_cfg) : 1'b1;
        slv_err[i]   = (i == 1) && (bus_addr[3:2] == 2'd3);
      end else begin
        slv_rdata[i*DW +: DW] = 32'hDEAD_BEE0 | 32'(i);
        slv_ready[i] = 1'b1;
        slv_err[i]   = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        wcnt[i] <= 0;
        for (int k = 0; k < 4; k++) mem[i][k] <= '0;
      end else begin
        if (bus_sel[i] && bus_enable && !slv_ready[i]) wcnt[i] <= wcnt[i] + 1;
        else wcnt[i] <= 0;
        if (bus_sel[i] && bus_enable && slv_ready[i] && bus_write && !slv_err[i])
          mem[i][bus_addr[3:2]] <= bus_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic run_vec(input vec_t v);
    bit mapped;
    logic [1:0] exp_sel;
    int lat;
    int exp_lat;
    bit bus_ok, sel_seen, ready_ok;
    mapped  = (v.addr >= 32'h1000) && (v.addr < 32'h1020);
    exp_sel = !mapped ? 2'b00 : (v.addr < 32'h1010 ? 2'b01 : 2'b10);
    exp_lat = mapped ? 3 + int'(v.wt) : 2;
    wait_cfg = int'(v.wt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = v.wr; cmd_addr = v.addr; cmd_wdata = v.wdata;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1; bus_ok = 1; sel_seen = 0; ready_ok = 1;
    while (!rsp_valid && lat < 20) begin
      if (bus_sel != 2'b00) sel_seen = 1;
      if (bus_enable && (bus_write !== v.wr || bus_sel !== exp_sel ||
                         bus_addr !== v.addr || (v.wr && bus_wdata !== v.wdata)))
        bus_ok = 0;
      if (bus_enable && wcnt[exp_sel[1]] < wait_cfg && cmd_ready) ready_ok = 0;
      @(negedge clk);
      lat++;
    end
    // R5 R6 direction, address and select seen during access
    if (mapped) check(bus_ok, "R5/R6 bus fields", {63'd0, bus_ok}, 64'd1);
    // R9 unmapped raises no select
    else check(!sel_seen, "R9 no select", {63'd0, sel_seen}, 64'd0);
    // R2 no acceptance during wait cycles
    check(ready_ok, "R2 ready in wait", {63'd0, ready_ok}, 64'd1);
    // R11 latency
    check(lat == exp_lat, "R11 latency", 64'(lat), 64'(exp_lat));
    // R8 R7 response contents
    check(rsp_valid && rsp_rdata === v.exp_rd, "R8/R7 rdata", 64'(rsp_rdata), 64'(v.exp_rd));
    check(rsp_err === v.exp_err, "R8/R9 err", 64'(rsp_err), 64'(v.exp_err));
    @(negedge clk);
    check(!rsp_valid, "R8 pulse", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    check(!cmd_ready && !rsp_valid && !rsp_err && rsp_rdata == 0 && bus_sel == 0 &&
          !bus_enable && !bus_write && bus_addr == 0 && bus_wdata == 0,
          "R1 reset outputs", {bus_sel, 1'b0, cmd_ready, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_ready && bus_sel == 0, "R1 idle after release", {bus_sel, cmd_ready}, 64'd1);

    for (int n = 0; n < NV; n++) run_vec(VECS[n]);

    // R10 back-to-back trace: 0x1000 then 0x1014, no waits
    wait_cfg = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 32'h1000;
    @(negedge clk);
    check(bus_sel == 2'b01 && !bus_enable && !cmd_ready, "R3 setup slave0",
          {bus_sel, bus_enable, cmd_ready}, 64'b0100);
    cmd_addr = 32'h1014;
    @(negedge clk);
    check(bus_sel == 2'b01 && bus_enable && cmd_ready, "R2 final access ready",
          {bus_sel, bus_enable, cmd_ready}, 64'b0111);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(bus_sel == 2'b10 && !bus_enable, "R10 direct setup", {bus_sel, bus_enable}, 64'b100);
    check(rsp_valid && rsp_rdata == 32'h1111_1111, "R10 first rsp", 64'(rsp_rdata), 64'h1111_1111);
    @(negedge clk);
    check(bus_sel == 2'b10 && bus_enable, "R10 second access", {bus_sel, bus_enable}, 64'b101);
    @(negedge clk);
    check(bus_sel == 2'b00 && rsp_valid && rsp_rdata == 32'h3333_3333, "R10 second rsp",
          64'(rsp_rdata), 64'h3333_3333);

    // R1 reset in the middle of a waited access
    wait_cfg = 3;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 32'h1004; cmd_wdata = 32'hABCD_0000;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check(bus_enable, "R4 in access", 64'(bus_enable), 64'd1);
    rst_n = 1'b0;
    #1;
    check(!bus_enable && bus_sel == 0 && bus_addr == 0 && !cmd_ready, "R1 async reset",
          {bus_sel, bus_enable, cmd_ready}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_ready && !rsp_valid, "R1 idle after mid reset", {cmd_ready, rsp_valid}, 64'b10);

    finish_run();
  end
endmodule